// File: doc/BRIEF.md
# Single-Wire Bus ROM Search Accelerator

This block speeds up device discovery on a single-wire bus. Search mode is a level input that stands for a bit in the host's command register. The host raises it after it has sent the search command byte as an ordinary write. From then on, each byte the host writes carries four preferred-path bits, one for each of four consecutive ROM bits. For each of those four ROM bits the block asks the shared bit-slot engine for two read slots: first the id bit, then its complement. It then decides the path and asks for one write slot that puts the chosen bit back on the bus.

When all four bits are done, the block returns one byte. That byte holds the four chosen bits and four discrepancy flags, interleaved. It also raises a receive-full flag, in the same way a normal byte read would. Sixteen such exchanges, least significant nibble first, walk the whole 64-bit ROM. The host keeps all path bookkeeping between passes, and clearing search mode ends the search.

Top module: `owm_search_accel`

## Requirements
- R1: After reset, `slotReq`, `rxFull` and `rxByte` are all zero.
- R2: An exchange starts only on `wrValid` while `searchEn` is high and no exchange is running. A write while search mode is off, or while an exchange is in progress, is ignored: it requests no slot, and a running exchange keeps the path bits it started with.
- R3: Each exchange issues exactly twelve slots, handling ROM bit 0 first. For each bit the order is read slot (id bit), read slot (complement), write slot (`slotWrite` 1 marks a write slot, 0 a read slot).
- R4: The preferred path for nibble bit k is taken from `wrData` bit 2k+1. The even bits of `wrData` are ignored.
- R5: If id/complement read 0/1, the block writes 0 with no discrepancy. If they read 1/0, it writes 1 with no discrepancy.
- R6: If id/complement read 0/0, the block flags a discrepancy and writes the preferred-path bit.
- R7: If id/complement read 1/1 (no device answering), the block flags a discrepancy and writes 1. On the last nibble this sets result bits 7 and 6 together, which the host reads as a bus error.
- R8: In `rxByte`, the chosen bit for nibble bit k sits at bit 2k+1 and its discrepancy flag at bit 2k.
- R9: `rxFull` rises two clock edges after the `slotDone` that ends the last write slot. It then stays high until `rdAck`, which clears it at the next edge.
- R10: While `slotReq` waits for `slotDone`, the request stays asserted, and during a write slot `slotWrite` and `slotWrBit` do not change.
- R11: Dropping `searchEn` during an exchange aborts it. `slotReq` is low from the next cycle on, and the block does not set `rxFull` for that exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| searchEn | input | 1 | Search mode, driven from the command register bit |
| wrValid | input | 1 | One-cycle strobe: host wrote the data register |
| wrData | input | 8 | Written byte; preferred paths on the odd bits |
| rdAck | input | 1 | Host read the result byte; clears `rxFull` |
| rxByte | output | 8 | Result: chosen bits (odd) and discrepancy flags (even) |
| rxFull | output | 1 | Result byte available |
| slotReq | output | 1 | Request one time slot from the bit-slot engine |
| slotWrite | output | 1 | 1 = write slot, 0 = read slot |
| slotWrBit | output | 1 | Bit to drive in a write slot |
| slotDone | input | 1 | One-cycle pulse: requested slot finished |
| slotRdBit | input | 1 | Sampled bus value of a finished read slot |

## Verification
The assertions watch the slot handshake on every cycle. They check that a pending request holds steady with a fixed direction and bit, that clearing search mode silences the slot requests within one cycle, that the result flag stays set until it is acknowledged, and that the flag rises only two edges after a completed write slot. Only the bench scenarios can show the decision table itself. They feed the engine model scripted id/complement answers, then compare the written bits, the slot order and the interleaved result byte against values computed from R4 to R8. The bench scenarios also cover the ignored writes and the aborted pass.

// File: rtl/owm_sra_pkg.sv
package owm_sra_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_RD_CMP,
    ST_WR_BIT,
    ST_DONE
  } sraState_t;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic loadPref;
    logic capId;
    logic capCmp;
    logic commit;
    logic publish;
  } sraStrobe_t;

endpackage

// File: rtl/owm_sra_ctrl.sv
module owm_sra_ctrl
  import owm_sra_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       searchEn,
  input  logic       wrValid,
  input  logic       slotDone,
  input  logic       lastBit,
  output sraStrobe_t strobe,
  output logic       slotReq,
  output logic       slotWrite
);

  sraState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    slotReq   = 1'b0;
    slotWrite = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (searchEn && wrValid) begin
          strobe.loadPref = 1'b1;
          stateNext       = ST_RD_ID;
        end
      end
      ST_RD_ID: begin
        slotReq = 1'b1;
        if (slotDone) begin
          strobe.capId = 1'b1;
          stateNext    = ST_RD_CMP;
        end
      end
      ST_RD_CMP: begin
        slotReq = 1'b1;
        if (slotDone) begin
          strobe.capCmp = 1'b1;
          stateNext     = ST_WR_BIT;
        end
      end
      ST_WR_BIT: begin
        slotReq   = 1'b1;
        slotWrite = 1'b1;
        if (slotDone) begin
          strobe.commit = 1'b1;
          stateNext     = lastBit ? ST_DONE : ST_RD_ID;
        end
      end
      ST_DONE: begin
        strobe.publish = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    // Leaving search mode abandons any exchange in flight.
    if (!searchEn && state != ST_IDLE) begin
      stateNext = ST_IDLE;
      strobe    = '0;
    end
  end

endmodule

// File: rtl/owm_sra_datapath.sv
module owm_sra_datapath
  import owm_sra_pkg::*;
#(
  parameter int BITS = 4,
  localparam int BYTE_W = 2 * BITS,
  localparam int IDX_W  = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sraStrobe_t        strobe,
  input  logic              rdAck,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              slotRdBit,
  output logic              chosenBit,
  output logic              lastBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxFull
);

  logic [BITS-1:0]   prefBits;
  logic [BITS-1:0]   chosenR;
  logic [BITS-1:0]   discR;
  logic [IDX_W-1:0]  bitIdx;
  logic              idBit;
  logic              cmpBit;
  logic              discNow;
  logic [BYTE_W-1:0] packNext;
  logic [BITS-1:0]   unusedEvenBits;

  genvar k;
  generate
    for (k = 0; k < BITS; k++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prefBits[k] <= 1'b0;
          chosenR[k]  <= 1'b0;
          discR[k]    <= 1'b0;
        end else begin
          if (strobe.loadPref) prefBits[k] <= wrData[2*k+1];
          if (strobe.commit && bitIdx == IDX_W'(k)) begin
            chosenR[k] <= chosenBit;
            discR[k]   <= discNow;
          end
        end
      end
      assign packNext[2*k+1]   = chosenR[k];
      assign packNext[2*k]     = discR[k];
      assign unusedEvenBits[k] = wrData[2*k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
      idBit  <= 1'b0;
      cmpBit <= 1'b0;
    end else begin
      if (strobe.loadPref)    bitIdx <= '0;
      else if (strobe.commit) bitIdx <= bitIdx + 1'b1;
      if (strobe.capId)  idBit  <= slotRdBit;
      if (strobe.capCmp) cmpBit <= slotRdBit;
    end
  end

  // Path decision: equal answers mean a discrepancy (both 0: follow the
  // host's preference, both 1: nobody answered, write 1).
  always_comb begin
    discNow = (idBit == cmpBit);
    if (!discNow)   chosenBit = idBit;
    else if (idBit) chosenBit = 1'b1;
    else            chosenBit = prefBits[bitIdx];
  end

  assign lastBit = (bitIdx == IDX_W'(BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      rxFull <= 1'b0;
    end else begin
      if (strobe.publish) begin
        rxByte <= packNext;
        rxFull <= 1'b1;
      end else if (rdAck) begin
        rxFull <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/owm_search_accel.sv
module owm_search_accel
  import owm_sra_pkg::*;
#(
  parameter int BITS = 4,
  localparam int BYTE_W = 2 * BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              searchEn,
  input  logic              wrValid,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdAck,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxFull,
  output logic              slotReq,
  output logic              slotWrite,
  output logic              slotWrBit,
  input  logic              slotDone,
  input  logic              slotRdBit
);

  sraStrobe_t strobe;
  logic       lastBit;
  logic       chosenBit;

  owm_sra_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .searchEn  (searchEn),
    .wrValid   (wrValid),
    .slotDone  (slotDone),
    .lastBit   (lastBit),
    .strobe    (strobe),
    .slotReq   (slotReq),
    .slotWrite (slotWrite)
  );

  owm_sra_datapath #(.BITS(BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdAck     (rdAck),
    .wrData    (wrData),
    .slotRdBit (slotRdBit),
    .chosenBit (chosenBit),
    .lastBit   (lastBit),
    .rxByte    (rxByte),
    .rxFull    (rxFull)
  );

  assign slotWrBit = chosenBit;

endmodule

// File: rtl/owm_search_accel_chk.sv
module owm_search_accel_chk (
  input logic clk,
  input logic rstN,
  input logic searchEn,
  input logic rdAck,
  input logic rxFull,
  input logic slotReq,
  input logic slotWrite,
  input logic slotWrBit,
  input logic slotDone
);

  // R10: a pending slot request holds, with direction and bit unchanged.
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && !slotDone && searchEn) |=> (slotReq && $stable(slotWrite)));

  p_wrbit_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && slotWrite && !slotDone && searchEn) |=> $stable(slotWrBit));

  // R11: leaving search mode silences the slot requests.
  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !searchEn |=> !slotReq);

  // R9: the result flag is sticky until acknowledged.
  p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rdAck) |=> rxFull);

  // R9: the flag rises two edges after a finished write slot.
  p_full_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> ($past(slotDone, 2) && $past(slotWrite, 2)));

  // R1: quiet outputs while held in reset.
  always_comb begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!slotReq && !rxFull);
    end
  end

endmodule

bind owm_search_accel owm_search_accel_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .searchEn  (searchEn),
  .rdAck     (rdAck),
  .rxFull    (rxFull),
  .slotReq   (slotReq),
  .slotWrite (slotWrite),
  .slotWrBit (slotWrBit),
  .slotDone  (slotDone)
);

// File: tb/sim_owm_search_accel.sv
`timescale 1ns/1ps
module sim_owm_search_accel;

  logic       clk = 1'b0;
  logic       rstN;
  logic       searchEn, wrValid, rdAck, slotDone, slotRdBit;
  logic [7:0] wrData, rxByte;
  logic       rxFull, slotReq, slotWrite, slotWrBit;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // Engine model bookkeeping.
  logic [3:0] scrId, scrCmp;
  logic [3:0] wrLog;
  int rdCnt, wrCnt, slotCnt;
  bit seqOk;

  // {id[3:0], cmp[3:0], wrData[7:0]}
  localparam logic [15:0] VEC [8] = '{
    16'hA5_00, 16'h00_AA, 16'h00_00, 16'hFF_00,
    16'h50_88, 16'h3C_22, 16'h89_0A, 16'h62_80
  };

  always #2.5 clk = ~clk;

  owm_search_accel u0 (
    .clk(clk), .rstN(rstN), .searchEn(searchEn), .wrValid(wrValid),
    .wrData(wrData), .rdAck(rdAck), .rxByte(rxByte), .rxFull(rxFull),
    .slotReq(slotReq), .slotWrite(slotWrite), .slotWrBit(slotWrBit),
    .slotDone(slotDone), .slotRdBit(slotRdBit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expectByte(input logic [3:0] id, input logic [3:0] cmp,
                                            input logic [7:0] wr);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (id[k] != cmp[k]) begin r[2*k+1] = id[k]; r[2*k] = 1'b0; end
      else if (id[k])      begin r[2*k+1] = 1'b1;  r[2*k] = 1'b1; end
      else                 begin r[2*k+1] = wr[2*k+1]; r[2*k] = 1'b1; end
    end
    return r;
  endfunction

  function automatic logic [3:0] chosenOf(input logic [7:0] b);
    return {b[7], b[5], b[3], b[1]};
  endfunction

  // Bit-slot engine model: answers each request after a short latency.
  initial begin
    slotDone = 1'b0;
    slotRdBit = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && slotReq) begin
        if (slotWrite) begin
          if (wrCnt < 4) wrLog[wrCnt] = slotWrBit;
          if (slotCnt % 3 != 2) seqOk = 1'b0;
          wrCnt++;
        end else begin
          slotRdBit = (rdCnt % 2 == 0) ? scrId[(rdCnt / 2) % 4] : scrCmp[(rdCnt / 2) % 4];
          if (slotCnt % 3 == 2) seqOk = 1'b0;
          rdCnt++;
        end
        slotCnt++;
        repeat (2) @(negedge clk);
        slotDone = 1'b1;
        @(negedge clk);
        slotDone = 1'b0;
      end
    end
  end

  task automatic clearLog(input logic [3:0] id, input logic [3:0] cmp);
    scrId = id; scrCmp = cmp;
    rdCnt = 0; wrCnt = 0; slotCnt = 0; seqOk = 1'b1; wrLog = '0;
  endtask

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk);
    wrValid = 1'b1; wrData = b;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitFull(output bit got);
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rxFull) begin got = 1'b1; break; end
    end
  endtask

  task automatic ackRead();
    rdAck = 1'b1;
    @(negedge clk);
    rdAck = 1'b0;
  endtask

  task automatic runExchange(input logic [3:0] id, input logic [3:0] cmp, input logic [7:0] wr);
    bit got;
    logic [7:0] exp;
    exp = expectByte(id, cmp, wr);
    clearLog(id, cmp);
    hostWrite(wr);
    waitFull(got);
    check(got, "R9 rxFull set after exchange", got, 1);
    check(rxByte == exp, "R8 R5 R6 R7 result byte", rxByte, exp);
    check(wrLog == chosenOf(exp), "R4 R5 R6 R7 written bits", wrLog, chosenOf(exp));
    check(rdCnt == 8 && wrCnt == 4 && seqOk, "R3 slot count and order",
          rdCnt * 16 + wrCnt, 8 * 16 + 4);
    ackRead();
    check(!rxFull, "R9 rdAck clears rxFull", rxFull, 0);
  endtask

  initial begin
    for (;;) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit got;
    rstN = 1'b0; searchEn = 1'b0; wrValid = 1'b0; wrData = '0; rdAck = 1'b0;
    clearLog('0, '0);
    repeat (3) @(negedge clk);
    check(!slotReq && !rxFull && rxByte == 8'h00, "R1 reset state",
          {slotReq, rxFull, rxByte}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: a write outside search mode is ignored.
    clearLog('0, '0);
    hostWrite(8'hFF);
    repeat (20) @(negedge clk);
    check(slotCnt == 0 && !rxFull, "R2 write ignored with search off", slotCnt, 0);

    searchEn = 1'b1;
    @(negedge clk);

    // Vector table.
    for (int v = 0; v < 8; v++) begin
      runExchange(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0]);
    end

    // R4: even bits of the written byte have no effect.
    runExchange(4'h0, 4'h0, 8'h55);

    // R7: all-nobody pass gives both top bits set (bus error signature).
    clearLog(4'hF, 4'hF);
    hostWrite(8'h00);
    waitFull(got);
    check(rxByte[7] && rxByte[6], "R7 bus error signature on last bit", rxByte[7:6], 3);
    // R9: held without acknowledge.
    repeat (6) @(negedge clk);
    check(rxFull, "R9 rxFull held until rdAck", rxFull, 1);
    ackRead();

    // R2: a second write during a running exchange is ignored.
    clearLog(4'h0, 4'h0);
    hostWrite(8'hAA);
    repeat (3) @(negedge clk);
    hostWrite(8'h00);
    waitFull(got);
    check(rxByte == 8'hFF && slotCnt == 12, "R2 write during exchange ignored", rxByte, 8'hFF);
    ackRead();

    // R11: abort by leaving search mode.
    clearLog(4'h0, 4'h0);
    hostWrite(8'hAA);
    repeat (8) @(negedge clk);
    searchEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!slotReq, "R11 no request after leaving search", slotReq, 0);
    repeat (60) @(negedge clk);
    check(!rxFull && wrCnt < 4, "R11 aborted exchange publishes nothing", rxFull, 0);

    // Re-entering search works from a clean start.
    searchEn = 1'b1;
    @(negedge clk);
    runExchange(4'h6, 4'h9, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule